// File: doc/BRIEF.md
# Dual-Rate Clock Enable Generator

This block runs on the oscillator clock and produces single-cycle enable strobes. One strobe marks machine cycles for the CPU. Six more strobes pace the peripherals: Timer0, Timer1, Timer2, the UART in its fixed-rate modes, the programmable counter array and the watchdog. All strobes come from one shared free-running counter. The fast enable fires every 6 oscillator clocks. The slow enable fires every 12, on every other fast enable.

The CPU runs either at 6 or at 12 oscillator clocks per machine cycle. A writable control byte selects the CPU rate, and a fuse input, when programmed, forces the 6-clock rate. In 6-clock mode, each peripheral picks the fast or the slow enable from its own control bit. In 12-clock mode, every peripheral uses the slow enable.

A reset qualifier passes the external reset pin through a two-flop synchronizer. It asserts the CPU reset only after the pin has stayed high for two machine cycles. When the CPU reset releases, it captures the external-access pin and holds that value.

Top module: `dual_rate_cken`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, the outputs read as follows: `cfg_o` = 00h, all strobes low, `cpu_rst_o` = 0 and `ext_acc_o` = 0.
- R2: In 12-clock mode, `mc_stb_o` and every bit of `per_stb_o` pulse for one cycle every 12 clocks. 12-clock mode means the fuse is clear and control bit 0 is 0. The first pulse comes 11 clocks after reset release, and all the pulses align.
- R3: With control bit 0 = 1, `mc_stb_o` pulses for one cycle every 6 clocks. These pulses fall in the cycles 5 and 11 of the shared 12-count.
- R4: In 6-clock mode, peripheral index i is controlled by control bit i+1. The indices are Timer0=0, Timer1=1, Timer2=2, UART=3, PCA=4 and watchdog=5. A bit value of 0 gives a strobe every 6 clocks, and a value of 1 gives a strobe every 12 clocks that coincides with every other 6-clock strobe.
- R5: In 12-clock mode, control bits 6..1 have no effect on any strobe.
- R6: With `fuse_fast_i` = 1, the block behaves as in 6-clock mode whatever control bit 0 holds.
- R7: A write is visible on `cfg_o` in the next cycle, and bit 7 always reads 0. The written value controls the strobes only after the next cycle in which the 12-clock enable fires.
- R8: `cpu_rst_o` rises only after the synchronized pin has been high for 24 clocks in 12-clock mode or 12 clocks in 6-clock mode. It rises at the edge 26 or 14 edges after the pin rises. If the pin drops before then, the count restarts. Once asserted, `cpu_rst_o` stays high while the pin stays high.
- R9: While `cpu_rst_o` is high, the control byte is cleared to 00h and writes are ignored.
- R10: `ext_acc_o` captures `ext_acc_i` at the edge where `cpu_rst_o` falls, and then ignores any change on `ext_acc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| fuse_fast_i | input | 1 | Programmed fuse that forces 6-clock mode |
| cfg_wr_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_o | output | 8 | Control byte readback |
| rst_pin_i | input | 1 | Raw external reset pin, active high |
| ext_acc_i | input | 1 | External-access pin |
| cpu_rst_o | output | 1 | Qualified CPU reset |
| ext_acc_o | output | 1 | External-access value captured at reset release |
| mc_stb_o | output | 1 | Machine-cycle strobe |
| per_stb_o | output | 6 | Peripheral enables, index order as in R4 |

## Verification
The bench builds the block with its defaults: FAST_DIV = 6 and HOLD_MC = 2. With these values, both the 6/12 strobe ratio and both reset hold windows (12 and 24 clocks) fit into runs of a few dozen cycles. As a result, the bench can exercise every rate combination, the cycle at which each write is applied, the restart of the hold count and the capture at release. It does all of this against a cycle model driven by the edge count since reset.

// File: rtl/dual_rate_cken_pkg.sv
package dual_rate_cken_pkg;
  localparam int unsigned NUM_PER = 6;
  localparam int unsigned CFG_W   = 8;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'h7F;

  typedef enum logic [2:0] {
    PER_T0   = 3'd0,
    PER_T1   = 3'd1,
    PER_T2   = 3'd2,
    PER_UART = 3'd3,
    PER_PCA  = 3'd4,
    PER_WDT  = 3'd5
  } per_idx_e;
endpackage

// File: rtl/dual_rate_div.sv
module dual_rate_div #(
  parameter int unsigned FAST_DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_fast_o,
  output logic tick_slow_o
);
  localparam int unsigned SLOW_DIV = 2 * FAST_DIV;
  localparam int unsigned CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_slow_o = (cnt_q == LAST);
  assign tick_fast_o = (cnt_q == LAST) || (cnt_q == MID);

  AST_SLOW_ON_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow_o |-> tick_fast_o); // R4
  AST_SLOW_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow_o |=> !tick_slow_o); // R2
  AST_FAST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_fast_o |=> !tick_fast_o); // R3
endmodule

// File: rtl/dual_rate_cfg.sv
module dual_rate_cfg
  import dual_rate_cken_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             commit_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rd_o,
  output logic [CFG_W-2:0] act_o
);
  logic [CFG_W-1:0] pend_q;
  logic [CFG_W-2:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else if (clr_i) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i)     pend_q <= wdata_i & CFG_MASK;
      if (commit_i) act_q  <= pend_q[CFG_W-2:0];
    end
  end

  assign rd_o  = pend_q;
  assign act_o = act_q;

  AST_ACT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clr_i) |=> $stable(act_q)); // R7
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rd_o == '0)); // R9
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_o[CFG_W-1]); // R7
endmodule

// File: rtl/dual_rate_rst_qual.sv
module dual_rate_rst_qual #(
  parameter int unsigned FAST_DIV = 6,
  parameter int unsigned HOLD_MC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic pin_i,
  input  logic ext_i,
  output logic cpu_rst_o,
  output logic ext_o
);
  localparam int unsigned THR_FAST = HOLD_MC * FAST_DIV;
  localparam int unsigned THR_SLOW = 2 * THR_FAST;
  localparam int unsigned HW = $clog2(THR_SLOW + 1);
  localparam logic [HW-1:0] LIM_FAST = HW'(THR_FAST - 1);
  localparam logic [HW-1:0] LIM_SLOW = HW'(THR_SLOW - 1);
  localparam logic [HW-1:0] SAT      = HW'(THR_SLOW);

  logic          s1_q, s2_q;
  logic [HW-1:0] hold_q;
  logic [HW-1:0] lim;
  logic          rst_q, ext_q, rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= '0;
    else if (!s2_q)      hold_q <= '0;
    else if (hold_q < SAT) hold_q <= hold_q + 1'b1;
  end

  assign lim = fast_i ? LIM_FAST : LIM_SLOW;
  assign rel = rst_q && !s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      rst_q <= s2_q && (rst_q || (hold_q >= lim));
      if (rel) ext_q <= ext_i;
    end
  end

  assign cpu_rst_o = rst_q;
  assign ext_o     = ext_q;

  AST_RST_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> ($past(hold_q) >= LIM_FAST)); // R8
  AST_RST_NEEDS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(s2_q)); // R8
  AST_EXT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel |=> $stable(ext_q)); // R10
endmodule

// File: rtl/dual_rate_cken.sv
module dual_rate_cken
  import dual_rate_cken_pkg::*;
#(
  parameter int unsigned FAST_DIV = 6,
  parameter int unsigned HOLD_MC  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fuse_fast_i,
  input  logic               cfg_wr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_o,
  input  logic               rst_pin_i,
  input  logic               ext_acc_i,
  output logic               cpu_rst_o,
  output logic               ext_acc_o,
  output logic               mc_stb_o,
  output logic [NUM_PER-1:0] per_stb_o
);
  logic             tick_fast, tick_slow, fast_mode, cpu_rst;
  logic [CFG_W-2:0] act;

  dual_rate_div #(.FAST_DIV(FAST_DIV)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_fast_o (tick_fast),
    .tick_slow_o (tick_slow)
  );

  dual_rate_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cpu_rst),
    .commit_i (tick_slow),
    .wr_i     (cfg_wr_i),
    .wdata_i  (cfg_wdata_i),
    .rd_o     (cfg_o),
    .act_o    (act)
  );

  assign fast_mode = fuse_fast_i | act[0];

  dual_rate_rst_qual #(.FAST_DIV(FAST_DIV), .HOLD_MC(HOLD_MC)) u_rq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fast_i    (fast_mode),
    .pin_i     (rst_pin_i),
    .ext_i     (ext_acc_i),
    .cpu_rst_o (cpu_rst),
    .ext_o     (ext_acc_o)
  );

  assign cpu_rst_o = cpu_rst;
  assign mc_stb_o  = fast_mode ? tick_fast : tick_slow;

  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    assign per_stb_o[i] = (fast_mode && !act[i+1]) ? tick_fast : tick_slow;

    AST_PER_SLOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_stb_o[i] && !tick_slow) |-> (fast_mode && !act[i+1])); // R4
  end

  AST_SLOW_MODE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_stb_o && !fast_mode) |-> (&per_stb_o)); // R5
  AST_FUSE_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_fast_i && tick_fast) |-> mc_stb_o); // R6
  AST_PER_ON_MC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|per_stb_o) |-> mc_stb_o); // R2
endmodule

// File: tb/dual_rate_cken_tb_top.sv
`timescale 1ns/100ps
module dual_rate_cken_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fuse_fast_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic [7:0] cfg_o;
  logic       rst_pin_i = 1'b0;
  logic       ext_acc_i = 1'b0;
  logic       cpu_rst_o, ext_acc_o, mc_stb_o;
  logic [5:0] per_stb_o;

  int checks = 0;
  int errors = 0;
  bit sb_on  = 1'b0;
  bit done   = 1'b0;
  int ph = 0;
  logic [7:0] pend_m = 8'h00;
  logic [7:0] act_m  = 8'h00;
  logic [7:0] wr_q[$];

  always #2.5 clk_i = ~clk_i;

  dual_rate_cken dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fuse_fast_i(fuse_fast_i),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_o(cfg_o),
    .rst_pin_i(rst_pin_i), .ext_acc_i(ext_acc_i), .cpu_rst_o(cpu_rst_o),
    .ext_acc_o(ext_acc_o), .mc_stb_o(mc_stb_o), .per_stb_o(per_stb_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(posedge clk_i);
    #1;
  endtask

  // driver: pushes the expected pending value for the monitor
  task automatic wr(input logic [7:0] v);
    cfg_wdata_i = v;
    cfg_wr_i    = 1'b1;
    wr_q.push_back(v & 8'h7F);
    tick(1);
    cfg_wr_i = 1'b0;
  endtask

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ph <= 0; else ph <= ph + 1;

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && sb_on) begin
      int c;
      logic t6, t12, fast;
      logic [6:0] exp_v;
      c    = ph % 12;
      t6   = (c == 5) || (c == 11);
      t12  = (c == 11);
      fast = fuse_fast_i | act_m[0];
      exp_v[6] = fast ? t6 : t12;
      for (int i = 0; i < 6; i++)
        exp_v[i] = (fast && !act_m[i+1]) ? t6 : t12;
      if (fuse_fast_i)   chk("R6 strobes", {mc_stb_o, per_stb_o}, exp_v);
      else if (act_m[0]) chk("R4 strobes", {mc_stb_o, per_stb_o}, exp_v);
      else               chk("R2 strobes", {mc_stb_o, per_stb_o}, exp_v);
      chk("R7 readback", cfg_o, pend_m);
      if (cpu_rst_o) begin
        pend_m = 8'h00;
        act_m  = 8'h00;
        if (cfg_wr_i && wr_q.size() > 0) void'(wr_q.pop_front());
      end else begin
        if (t12) act_m = pend_m;
        if (cfg_wr_i && wr_q.size() > 0) pend_m = wr_q.pop_front();
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 cfg in reset", cfg_o, 8'h00);
    chk("R1 strobes in reset", {mc_stb_o, per_stb_o}, 7'h00);
    chk("R1 cpu_rst in reset", cpu_rst_o, 1'b0);
    chk("R1 ext in reset", ext_acc_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sb_on  = 1'b1;
    #1;
    chk("R1 first cycle strobes", {mc_stb_o, per_stb_o}, 7'h00);
    tick(36);                 // R2
    wr(8'h7E); tick(40);      // R5
    wr(8'h00); tick(20);
    wr(8'h01); tick(48);      // R3 R4
    wr(8'h55); tick(48);      // R4
    wr(8'hAB); tick(2);
    chk("R7 reserved bit", cfg_o, 8'h2B);
    tick(40);
    wr(8'h01); tick(30);
    // R7: write mid machine-cycle, applied only at the 12-clock boundary
    wr(8'h7F); tick(30);
    wr(8'h00); tick(24);
    fuse_fast_i = 1'b1; tick(36);  // R6
    wr(8'h7E); tick(36);
    wr(8'h00); tick(24);
    fuse_fast_i = 1'b0; tick(24);

    // R8 12-clock mode hold window
    ext_acc_i = 1'b1;
    rst_pin_i = 1'b1;
    tick(25); @(negedge clk_i);
    chk("R8 not yet (24)", cpu_rst_o, 1'b0);
    tick(1); @(negedge clk_i);
    chk("R8 asserted (24)", cpu_rst_o, 1'b1);
    tick(5);
    chk("R9 cleared", cfg_o, 8'h00);
    rst_pin_i = 1'b0;
    tick(3); @(negedge clk_i);
    chk("R8 released", cpu_rst_o, 1'b0);
    chk("R10 captured 1", ext_acc_o, 1'b1);
    tick(1);
    ext_acc_i = 1'b0; tick(6);
    chk("R10 later change ignored", ext_acc_o, 1'b1);

    // R8 6-clock mode with restart
    wr(8'h01); tick(30);
    rst_pin_i = 1'b1; tick(8);
    rst_pin_i = 1'b0; tick(3);
    chk("R8 short pulse", cpu_rst_o, 1'b0);
    rst_pin_i = 1'b1;
    tick(13); @(negedge clk_i);
    chk("R8 restart not yet (12)", cpu_rst_o, 1'b0);
    tick(1); @(negedge clk_i);
    chk("R8 asserted (12)", cpu_rst_o, 1'b1);
    tick(1);
    wr(8'h7F); tick(2);
    chk("R9 write ignored", cfg_o, 8'h00);
    rst_pin_i = 1'b0;
    tick(6);
    chk("R10 captured 0", ext_acc_o, 1'b0);
    ext_acc_i = 1'b1; tick(6);
    chk("R10 ignored 1", ext_acc_o, 1'b0);
    tick(24);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule